// File: doc/BRIEF.md
# Block Memory Micro-Op Sequencer

This block sits behind the instruction decoder and turns one block load or block store into a fixed run of eight doubleword memory micro-operations. An instruction arrives on a valid/ready port together with its address form (two registers, or base register plus a signed 13-bit immediate), the operand values, the first floating-point register number, the privilege level and the address-space identifier. The sequencer then presents the micro-ops one at a time on a valid/ready output port. Each micro-op carries its effective address, its register index, the load/store kind and the position flags that the commit logic uses.

The fault checks run once per instruction, on the base effective address, before micro-op 0 would go out. A faulting instruction produces a one-cycle fault report in place of any micro-op, and the sequencer is free for the next instruction on the cycle after that. The memory system, the register file and the data transfer are handled by other blocks.

Top module: `blk_uop_seq`

## Requirements
- R1: An instruction is accepted on a cycle with `inValid` and `inReady` both high. `inReady` is high only while the sequencer is idle. It stays low from the accept until the handshake of micro-op 7. After that handshake it is high again and `uopValid` is low.
- R2: In register form (`inUseImm`=0), micro-op i (`uopNum`=i, 0..7) has address `inBase + inIndex + 8*i`, modulo 2^ADDR_W.
- R3: In immediate form (`inUseImm`=1), micro-op i has address `inBase + sext(inImm) + 8*i`, modulo 2^ADDR_W. Bit 12 of `inImm` is the sign.
- R4: Micro-op 0 has `uopFirst`=1, `uopLast`=0 and `uopDelay`=1. Micro-ops 1 to 6 have `uopFirst`=0, `uopLast`=0 and `uopDelay`=1. Micro-op 7 has `uopFirst`=0, `uopLast`=1 and `uopDelay`=0.
- R5: Micro-op i has `uopReg` = (`inReg` + 2*i) modulo 2^REG_W. `uopIsStore` equals the `inIsStore` value that was captured when the instruction was accepted.
- R6: If bits [5:0] of the base effective address (the micro-op 0 address) are not all zero, the instruction reports an alignment fault, with code 2.
- R7: If `inPriv`=0 and `inAsi` < 0x80, the instruction reports a privilege fault, with code 1. When this condition and the alignment condition both hold, the reported code is 2.
- R8: A faulting instruction drives `faultValid`=1 with its code for exactly one cycle, the cycle after the accept. During that cycle `uopValid` stays low. No micro-op is issued for the instruction, and `inReady` is high on the next cycle.
- R9: While `uopValid`=1 and `uopReady`=0, the micro-op number, address, register, kind and flags hold their values. The sequence moves on only on a handshake.
- R10: For an instruction that does not fault, `faultValid` stays 0 and `faultCode` reads 0 (no fault) for the whole issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction present |
| inReady | output | 1 | Sequencer idle, can accept |
| inIsStore | input | 1 | 1 = block store, 0 = block load |
| inUseImm | input | 1 | 1 = immediate form, 0 = register form |
| inBase | input | ADDR_W | Base register value |
| inIndex | input | ADDR_W | Index register value (register form) |
| inImm | input | 13 | Signed immediate (immediate form) |
| inReg | input | REG_W | First FP register number |
| inPriv | input | 1 | Privileged mode |
| inAsi | input | 8 | Address-space identifier |
| uopValid | output | 1 | Micro-op present |
| uopReady | input | 1 | Downstream takes the micro-op |
| uopNum | output | 3 | Micro-op position 0..7 |
| uopAddr | output | ADDR_W | Effective address |
| uopReg | output | REG_W | Register index |
| uopIsStore | output | 1 | Store kind |
| uopFirst | output | 1 | First micro-op flag |
| uopLast | output | 1 | Last micro-op flag |
| uopDelay | output | 1 | Delayed-commit flag |
| faultValid | output | 1 | Fault report strobe |
| faultCode | output | 2 | 0 none, 1 privilege, 2 alignment |

## Verification
The hardest case to reach from the ports is a back-pressure stall that falls on each micro-op position in turn, including the first and the last. Each instruction in the sweep therefore gets a different stall phase, which moves the cycle with `uopReady` low across all eight positions. The sweep also covers both address forms, both kinds, negative immediates, address wrap-around and register-number wrap-around, misalignment with and without the privilege condition, and identifiers on each side of 0x80.

// File: rtl/blk_uop_seq_pkg.sv
package blk_uop_seq_pkg;
  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_PRIV  = 2'd1,
    FLT_ALIGN = 2'd2
  } faultKind_e;

  typedef struct packed {
    logic load;    // capture the instruction
    logic active;  // a micro-op is being presented
  } ctrlStrobe_t;
endpackage

// File: rtl/blk_uop_seq_ctrl.sv
module blk_uop_seq_ctrl
  import blk_uop_seq_pkg::*;
#(
  parameter int UOP_N = 8,
  localparam int CNT_W = $clog2(UOP_N)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             faultNow,
  input  logic             uopReady,
  output logic             inReady,
  output logic             uopValid,
  output logic             faultValid,
  output logic [CNT_W-1:0] cnt,
  output ctrlStrobe_t      strobe
);
  localparam logic [CNT_W-1:0] LastCnt = CNT_W'(UOP_N - 1);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_FAULT} state_e;
  state_e state;

  logic accept;
  assign accept = inValid && (state == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          state <= faultNow ? S_FAULT : S_ISSUE;
          cnt   <= '0;
        end
        S_ISSUE: if (uopReady) begin
          if (cnt == LastCnt) state <= S_IDLE;
          cnt <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign inReady       = (state == S_IDLE);
  assign uopValid      = (state == S_ISSUE);
  assign faultValid    = (state == S_FAULT);
  assign strobe.load   = accept;
  assign strobe.active = (state == S_ISSUE);
endmodule

// File: rtl/blk_uop_seq_dp.sv
module blk_uop_seq_dp
  import blk_uop_seq_pkg::*;
#(
  parameter int          ADDR_W     = 64,
  parameter int          REG_W      = 6,
  parameter int          IMM_W      = 13,
  parameter int          ASI_W      = 8,
  parameter int          UOP_N      = 8,
  parameter int          STEP_BYTES = 8,
  parameter int          REG_STRIDE = 2,
  parameter int          ALIGN_LOG2 = 6,
  parameter logic [7:0]  ASI_OPEN   = 8'h80,
  localparam int         CNT_W      = $clog2(UOP_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              inIsStore,
  input  logic              inUseImm,
  input  logic [ADDR_W-1:0] inBase,
  input  logic [ADDR_W-1:0] inIndex,
  input  logic [IMM_W-1:0]  inImm,
  input  logic [REG_W-1:0]  inReg,
  input  logic              inPriv,
  input  logic [ASI_W-1:0]  inAsi,
  output logic              faultNow,
  output logic [ADDR_W-1:0] uopAddr,
  output logic [REG_W-1:0]  uopReg,
  output logic              uopIsStore,
  output logic              uopFirst,
  output logic              uopLast,
  output logic              uopDelay,
  output faultKind_e        faultKind
);
  localparam logic [CNT_W-1:0] LastCnt = CNT_W'(UOP_N - 1);

  logic [ADDR_W-1:0] immExt, eaNow, baseEa;
  logic [REG_W-1:0]  baseReg;
  logic              alignBad, privBad;
  faultKind_e        kindNow;

  assign immExt   = {{(ADDR_W-IMM_W){inImm[IMM_W-1]}}, inImm};
  assign eaNow    = inBase + (inUseImm ? immExt : inIndex);
  assign alignBad = |eaNow[ALIGN_LOG2-1:0];
  assign privBad  = !inPriv && (inAsi < ASI_W'(ASI_OPEN));

  // alignment is evaluated last and therefore wins
  always_comb begin
    kindNow = FLT_NONE;
    if (privBad)  kindNow = FLT_PRIV;
    if (alignBad) kindNow = FLT_ALIGN;
  end
  assign faultNow = (kindNow != FLT_NONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseEa     <= '0;
      baseReg    <= '0;
      uopIsStore <= 1'b0;
      faultKind  <= FLT_NONE;
    end else if (strobe.load) begin
      baseEa     <= eaNow;
      baseReg    <= inReg;
      uopIsStore <= inIsStore;
      faultKind  <= kindNow;
    end
  end

  assign uopAddr  = baseEa + ADDR_W'(cnt) * ADDR_W'(STEP_BYTES);
  assign uopReg   = baseReg + REG_W'(cnt) * REG_W'(REG_STRIDE);
  assign uopFirst = strobe.active && (cnt == '0);
  assign uopLast  = strobe.active && (cnt == LastCnt);
  assign uopDelay = strobe.active && (cnt != LastCnt);
endmodule

// File: rtl/blk_uop_seq.sv
module blk_uop_seq
  import blk_uop_seq_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int REG_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic              inIsStore,
  input  logic              inUseImm,
  input  logic [ADDR_W-1:0] inBase,
  input  logic [ADDR_W-1:0] inIndex,
  input  logic [12:0]       inImm,
  input  logic [REG_W-1:0]  inReg,
  input  logic              inPriv,
  input  logic [7:0]        inAsi,
  output logic              uopValid,
  input  logic              uopReady,
  output logic [2:0]        uopNum,
  output logic [ADDR_W-1:0] uopAddr,
  output logic [REG_W-1:0]  uopReg,
  output logic              uopIsStore,
  output logic              uopFirst,
  output logic              uopLast,
  output logic              uopDelay,
  output logic              faultValid,
  output logic [1:0]        faultCode
);
  ctrlStrobe_t strobe;
  logic [2:0]  cnt;
  logic        faultNow;
  faultKind_e  faultKind;

  blk_uop_seq_ctrl #(.UOP_N(8)) ctrlI (
    .clk(clk), .rstN(rstN), .inValid(inValid), .faultNow(faultNow),
    .uopReady(uopReady), .inReady(inReady), .uopValid(uopValid),
    .faultValid(faultValid), .cnt(cnt), .strobe(strobe)
  );

  blk_uop_seq_dp #(.ADDR_W(ADDR_W), .REG_W(REG_W), .UOP_N(8)) dpI (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cnt(cnt),
    .inIsStore(inIsStore), .inUseImm(inUseImm), .inBase(inBase),
    .inIndex(inIndex), .inImm(inImm), .inReg(inReg), .inPriv(inPriv),
    .inAsi(inAsi), .faultNow(faultNow), .uopAddr(uopAddr),
    .uopReg(uopReg), .uopIsStore(uopIsStore), .uopFirst(uopFirst),
    .uopLast(uopLast), .uopDelay(uopDelay), .faultKind(faultKind)
  );

  assign uopNum    = cnt;
  assign faultCode = faultValid ? faultKind : FLT_NONE;
endmodule

// File: rtl/blk_uop_seq_chk.sv
module blk_uop_seq_chk #(
  parameter int ADDR_W = 64,
  parameter int REG_W  = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic              uopValid,
  input logic              uopReady,
  input logic [2:0]        uopNum,
  input logic [ADDR_W-1:0] uopAddr,
  input logic [REG_W-1:0]  uopReg,
  input logic              uopIsStore,
  input logic              uopFirst,
  input logic              uopLast,
  input logic              uopDelay,
  input logic              faultValid,
  input logic [1:0]        faultCode
);
  a_r1_accept_starts: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> (uopValid && uopNum == 3'd0) || faultValid);

  a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    uopValid |-> !inReady);

  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    uopValid && uopReady && !uopLast |=>
      uopValid && uopAddr == $past(uopAddr) + ADDR_W'(8));

  a_r4_flags: assert property (@(posedge clk) disable iff (!rstN)
    uopValid |-> $onehot0({uopFirst, uopLast}) && (uopDelay != uopLast)
                 && (uopFirst == (uopNum == 3'd0)) && (uopLast == (uopNum == 3'd7)));

  a_r5_reg_step: assert property (@(posedge clk) disable iff (!rstN)
    uopValid && uopReady && !uopLast |=>
      uopReg == $past(uopReg) + REG_W'(2) && uopIsStore == $past(uopIsStore));

  a_r8_fault_alone: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> !uopValid && faultCode != 2'd0);

  a_r8_fault_then_idle: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |=> inReady && !faultValid);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    uopValid && !uopReady |=> uopValid && $stable(uopNum) && $stable(uopAddr)
      && $stable(uopReg) && $stable(uopIsStore));

  a_r10_quiet_code: assert property (@(posedge clk) disable iff (!rstN)
    !faultValid |-> faultCode == 2'd0);
endmodule

bind blk_uop_seq blk_uop_seq_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W)) chkI (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .uopValid(uopValid), .uopReady(uopReady), .uopNum(uopNum),
  .uopAddr(uopAddr), .uopReg(uopReg), .uopIsStore(uopIsStore),
  .uopFirst(uopFirst), .uopLast(uopLast), .uopDelay(uopDelay),
  .faultValid(faultValid), .faultCode(faultCode)
);

// File: tb/blk_uop_seq_test.sv
module blk_uop_seq_test;
  localparam int AW = 16;
  localparam int RW = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inIsStore = 1'b0, inUseImm = 1'b0, inPriv = 1'b0;
  logic [AW-1:0] inBase = '0, inIndex = '0;
  logic [12:0]   inImm = '0;
  logic [RW-1:0] inReg = '0;
  logic [7:0]    inAsi = '0;
  logic          uopReady = 1'b0;
  logic          inReady, uopValid, uopIsStore, uopFirst, uopLast, uopDelay, faultValid;
  logic [2:0]    uopNum;
  logic [AW-1:0] uopAddr;
  logic [RW-1:0] uopReg;
  logic [1:0]    faultCode;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  blk_uop_seq #(.ADDR_W(AW), .REG_W(RW)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inIsStore(inIsStore), .inUseImm(inUseImm), .inBase(inBase),
    .inIndex(inIndex), .inImm(inImm), .inReg(inReg), .inPriv(inPriv),
    .inAsi(inAsi), .uopValid(uopValid), .uopReady(uopReady),
    .uopNum(uopNum), .uopAddr(uopAddr), .uopReg(uopReg),
    .uopIsStore(uopIsStore), .uopFirst(uopFirst), .uopLast(uopLast),
    .uopDelay(uopDelay), .faultValid(faultValid), .faultCode(faultCode)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic checkUop(input string req, input int i, input logic [AW-1:0] ea,
                          input logic [RW-1:0] rg, input bit st);
    logic [AW-1:0] expA;
    logic [RW-1:0] expR;
    expA = ea + AW'(8 * i);
    expR = rg + RW'(2 * i);
    check(uopValid === 1'b1, "R1", "uopValid", uopValid, 1);
    check(uopNum === 3'(i), "R1", "uopNum", uopNum, i);
    check(uopAddr === expA, req, "uopAddr", uopAddr, expA);
    check(uopReg === expR, "R5", "uopReg", uopReg, expR);
    check(uopIsStore === st, "R5", "uopIsStore", uopIsStore, st);
    check(uopFirst === (i == 0), "R4", "uopFirst", uopFirst, i == 0);
    check(uopLast === (i == 7), "R4", "uopLast", uopLast, i == 7);
    check(uopDelay === (i != 7), "R4", "uopDelay", uopDelay, i != 7);
    check(inReady === 1'b0, "R1", "inReady busy", inReady, 0);
    check(faultValid === 1'b0 && faultCode === 2'd0, "R10", "fault quiet",
          {faultValid, faultCode}, 0);
  endtask

  task automatic runOne(input bit st, input bit useImm, input logic [AW-1:0] base,
                        input logic [AW-1:0] idx, input logic [12:0] imm,
                        input logic [RW-1:0] rg, input bit priv,
                        input logic [7:0] asi, input int phase);
    logic [AW-1:0] ea;
    int expCode;
    string formReq;
    ea = base + (useImm ? {{(AW-13){imm[12]}}, imm} : idx);
    formReq = useImm ? "R3" : "R2";
    if (ea[5:0] != 6'd0) expCode = 2;
    else if (!priv && asi < 8'h80) expCode = 1;
    else expCode = 0;

    @(negedge clk);
    inValid = 1'b1; inIsStore = st; inUseImm = useImm; inBase = base;
    inIndex = idx; inImm = imm; inReg = rg; inPriv = priv; inAsi = asi;
    check(inReady === 1'b1, "R1", "inReady idle", inReady, 1);
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    inIsStore = ~st; inReg = ~rg; inBase = ~base;  // captured values must hold

    if (expCode != 0) begin
      check(faultValid === 1'b1, "R8", "faultValid", faultValid, 1);
      check(faultCode === 2'(expCode), expCode == 2 ? "R6" : "R7", "faultCode",
            faultCode, expCode);
      check(uopValid === 1'b0, "R8", "uopValid on fault", uopValid, 0);
      @(posedge clk);
      @(negedge clk);
      check(faultValid === 1'b0 && inReady === 1'b1 && uopValid === 1'b0, "R8",
            "after fault", {faultValid, inReady, uopValid}, 3'b010);
      return;
    end

    for (int i = 0; i < 8; i++) begin
      checkUop(formReq, i, ea, rg, st);
      if ((i + phase) % 8 == 0) begin
        uopReady = 1'b0;
        @(posedge clk);
        @(negedge clk);
        checkUop("R9", i, ea, rg, st);
      end
      uopReady = 1'b1;
      @(posedge clk);
      @(negedge clk);
      uopReady = 1'b0;
    end
    check(uopValid === 1'b0 && inReady === 1'b1, "R1", "idle after last",
          {uopValid, inReady}, 2'b01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(inReady === 1'b1 && uopValid === 1'b0 && faultValid === 1'b0, "R1",
          "reset state", {inReady, uopValid, faultValid}, 3'b100);
    rstN = 1'b1;

    begin
      int n;
      logic [5:0] misal [3];
      logic [7:0] asiSel [3];
      bit privSel [3];
      misal[0] = 6'd0; misal[1] = 6'd8; misal[2] = 6'd33;
      asiSel[0] = 8'h80; asiSel[1] = 8'h7F; asiSel[2] = 8'h05;
      privSel[0] = 1'b0; privSel[1] = 1'b0; privSel[2] = 1'b1;
      n = 0;
      for (int form = 0; form < 2; form++)
        for (int st = 0; st < 2; st++)
          for (int m = 0; m < 3; m++)
            for (int p = 0; p < 3; p++) begin
              logic [AW-1:0] base, idx;
              logic [12:0] imm;
              base = (n % 4 == 3) ? 16'hFFC0 : AW'(16'h1000 + n * 16'h40);
              idx  = AW'(16'h0F80) + AW'(misal[m]);
              imm  = (n % 2 == 1) ? (13'h1F80 + 13'(misal[m]))
                                  : (13'h0040 + 13'(misal[m]));
              runOne(st[0], form[0], base, idx, imm, RW'(n * 7 + 50),
                     privSel[p], asiSel[p], n);
              n++;
            end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule